// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block holds the tap setting of an output delay line and applies the rules for changing it. It is clocked by a control clock. Clock-enable, direction, load and pipeline-load strobes, together with a parallel count input, act on a tap counter. The current count is driven out on every cycle. The analog delay elements that consume the count are outside the block.

A static mode parameter selects the behaviour. In fixed mode the count is a constant. In variable mode the count only steps up and down. In load mode it also takes a direct parallel load. In pipelined-load mode a value is first staged in a holding register and moved into the counter by a later load strobe. When a parameter enables it, an input can invert the polarity of the control clock while the block runs.

Top module: `dly_tap_ctrl`

## Requirements
- R1: With MODE = TAP_FIXED, `tap_cnt` always equals INIT_TAP, whatever the strobes, the count input or the reset do.
- R2: Synchronous reset sets `tap_cnt` to INIT_TAP in TAP_VAR mode and to 0 in TAP_LOAD and TAP_LOAD_PIPE modes, where INIT_TAP has no effect. The new value shows after the first control clock edge with `rst` = 1.
- R3: In the three non-fixed modes, `step_en` = 1 with `step_up` = 1 adds one to the count and `step_en` = 1 with `step_up` = 0 subtracts one, on the control clock edge. With `step_en` = 0 and no load, the count holds whatever `step_up` is.
- R4: Stepping up from 31 gives 0 and stepping down from 0 gives 31 (modulo 2^TAP_W).
- R5: In TAP_LOAD mode, `load` = 1 copies `cnt_in` into the count on the next edge. `stage` has no effect in this mode.
- R6: In TAP_VAR mode, `load` and `stage` have no effect.
- R7: When `load` and `step_en` are both 1 in a load mode, the load happens and no step is taken.
- R8: In TAP_LOAD_PIPE mode, `stage` = 1 captures `cnt_in` into a holding register without changing the count. `load` = 1 moves the held value into the count. When `stage` and `load` come in the same cycle, the count takes the value held before that edge and the new `cnt_in` is held.
- R9: Reset wins over every strobe and clears the holding register, so a load right after reset in TAP_LOAD_PIPE mode gives 0.
- R10: With CLK_INV_EN = 1 and `clk_inv` = 1, the block updates on the falling edge of `clk`. With CLK_INV_EN = 0, `clk_inv` has no effect and updates stay on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| clk_inv | input | 1 | Control clock polarity invert (used only when CLK_INV_EN = 1) |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Enables a one-tap step |
| step_up | input | 1 | Step direction: 1 adds a tap, 0 removes one |
| load | input | 1 | Loads the count (from `cnt_in`, or from the holding register in pipelined mode) |
| stage | input | 1 | Captures `cnt_in` into the holding register (pipelined mode only) |
| cnt_in | input | TAP_W | Parallel count value |
| tap_cnt | output | TAP_W | Current tap count |

## Verification
The bench runs one instance of each mode from a shared stimulus stream. It checks the load-over-step priority, which a design with the order reversed would fail by stepping from the old count. It checks a load and a stage in the same cycle, where a design that bypassed the holding register would load the new input instead of the old held value. It also checks a load right after a reset that came with a stage strobe, which exposes a holding register that is not cleared or that captures during reset. The wrap in both directions is driven at 31 and at 0, where a saturating counter would stick. The clock inversion is checked by looking at the count between a rising and a falling edge: a design that ignored the invert would still be unchanged there, and an instance with inversion disabled that reacted would have moved.

// File: rtl/dly_tap_pkg.sv
`timescale 1ns/1ps
package dly_tap_pkg;

   typedef enum logic [1:0] {
      TAP_FIXED     = 2'd0,
      TAP_VAR       = 2'd1,
      TAP_LOAD      = 2'd2,
      TAP_LOAD_PIPE = 2'd3
   } tap_mode_e;

   function automatic bit mode_steps(tap_mode_e m);
      return m != TAP_FIXED;
   endfunction

   function automatic bit mode_loads(tap_mode_e m);
      return (m == TAP_LOAD) || (m == TAP_LOAD_PIPE);
   endfunction

endpackage

// File: rtl/dly_tap_clk_sel.sv
`timescale 1ns/1ps
module dly_tap_clk_sel #(
   parameter bit INV_EN = 1'b0
) (
   input  logic clk,
   input  logic clk_inv,
   output logic ctl_clk
);

   generate
      if (INV_EN) begin : g_inv
         assign ctl_clk = clk ^ clk_inv;
      end else begin : g_pass
         logic unused_inv;
         assign unused_inv = clk_inv;
         assign ctl_clk    = clk;
      end
   endgenerate

endmodule

// File: rtl/dly_tap_hold.sv
`timescale 1ns/1ps
module dly_tap_hold #(
   parameter int unsigned TAP_W = 5,
   parameter bit          EN    = 1'b0
) (
   input  logic             ctl_clk,
   input  logic             rst,
   input  logic             stage,
   input  logic [TAP_W-1:0] cnt_in,
   output logic [TAP_W-1:0] hold_q
);

   generate
      if (EN) begin : g_reg
         always_ff @(posedge ctl_clk) begin
            if (rst) begin
               hold_q <= '0;
            end else if (stage) begin
               hold_q <= cnt_in;
            end
         end
      end else begin : g_none
         logic unused_hold;
         assign unused_hold = ^{ctl_clk, rst, stage, cnt_in};
         assign hold_q      = '0;
      end
   endgenerate

endmodule

// File: rtl/dly_tap_cnt.sv
`timescale 1ns/1ps
module dly_tap_cnt
   import dly_tap_pkg::*;
#(
   parameter int unsigned TAP_W = 5,
   parameter tap_mode_e   MODE  = TAP_FIXED,
   parameter int unsigned START = 0
) (
   input  logic             ctl_clk,
   input  logic             rst,
   input  logic             step_en,
   input  logic             step_up,
   input  logic             load,
   input  logic [TAP_W-1:0] ld_val,
   output logic [TAP_W-1:0] cnt_q
);

   localparam logic [TAP_W-1:0] START_V = TAP_W'(START);
   localparam logic [TAP_W-1:0] ONE_V   = TAP_W'(1);
   localparam bit               CAN_LD  = mode_loads(MODE);

   generate
      if (!mode_steps(MODE)) begin : g_fixed
         logic unused_ctl;
         assign unused_ctl = ^{ctl_clk, rst, step_en, step_up, load, ld_val};
         assign cnt_q      = START_V;
      end else begin : g_count
         logic             ld_use;
         logic [TAP_W-1:0] cnt_nxt;

         assign ld_use = CAN_LD & load;

         always_comb begin
            cnt_nxt = cnt_q;
            if (ld_use) begin
               cnt_nxt = ld_val;
            end else if (step_en) begin
               cnt_nxt = step_up ? (cnt_q + ONE_V) : (cnt_q - ONE_V);
            end
         end

         always_ff @(posedge ctl_clk) begin
            if (rst) begin
               cnt_q <= START_V;
            end else begin
               cnt_q <= cnt_nxt;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dly_tap_ctrl.sv
`timescale 1ns/1ps
module dly_tap_ctrl
   import dly_tap_pkg::*;
#(
   parameter int unsigned TAP_W      = 5,
   parameter int unsigned INIT_TAP   = 0,
   parameter tap_mode_e   MODE       = TAP_FIXED,
   parameter bit          CLK_INV_EN = 1'b0
) (
   input  logic             clk,
   input  logic             clk_inv,
   input  logic             rst,
   input  logic             step_en,
   input  logic             step_up,
   input  logic             load,
   input  logic             stage,
   input  logic [TAP_W-1:0] cnt_in,
   output logic [TAP_W-1:0] tap_cnt
);

   localparam bit          PIPE_MODE = (MODE == TAP_LOAD_PIPE);
   localparam int unsigned START     = mode_loads(MODE) ? 0 : INIT_TAP;

   generate
      if (TAP_W < 1 || TAP_W > 16) begin : g_bad_w
         $error("dly_tap_ctrl: TAP_W out of range 1..16");
      end
      if (INIT_TAP >= (1 << TAP_W)) begin : g_bad_init
         $error("dly_tap_ctrl: INIT_TAP does not fit in TAP_W bits");
      end
   endgenerate

   logic             ctl_clk;
   logic [TAP_W-1:0] hold_q;
   logic [TAP_W-1:0] ld_val;

   dly_tap_clk_sel #(
      .INV_EN (CLK_INV_EN)
   ) u_clk_sel (
      .clk     (clk),
      .clk_inv (clk_inv),
      .ctl_clk (ctl_clk)
   );

   dly_tap_hold #(
      .TAP_W (TAP_W),
      .EN    (PIPE_MODE)
   ) u_hold (
      .ctl_clk (ctl_clk),
      .rst     (rst),
      .stage   (stage),
      .cnt_in  (cnt_in),
      .hold_q  (hold_q)
   );

   assign ld_val = PIPE_MODE ? hold_q : cnt_in;

   dly_tap_cnt #(
      .TAP_W (TAP_W),
      .MODE  (MODE),
      .START (START)
   ) u_cnt (
      .ctl_clk (ctl_clk),
      .rst     (rst),
      .step_en (step_en),
      .step_up (step_up),
      .load    (load),
      .ld_val  (ld_val),
      .cnt_q   (tap_cnt)
   );

endmodule

// File: rtl/dly_tap_ctrl_chk.sv
`timescale 1ns/1ps
module dly_tap_ctrl_chk
   import dly_tap_pkg::*;
#(
   parameter int unsigned TAP_W    = 5,
   parameter int unsigned INIT_TAP = 0,
   parameter tap_mode_e   MODE     = TAP_FIXED
) (
   input logic             ctl_clk,
   input logic             rst,
   input logic             step_en,
   input logic             step_up,
   input logic             load,
   input logic [TAP_W-1:0] cnt_in,
   input logic [TAP_W-1:0] hold_q,
   input logic [TAP_W-1:0] tap_cnt
);

   localparam logic [TAP_W-1:0] START_V = mode_loads(MODE) ? '0 : TAP_W'(INIT_TAP);
   localparam bit               STEPS   = mode_steps(MODE);
   localparam bit               LOADS   = mode_loads(MODE);
   localparam logic [TAP_W-1:0] ONE_V   = TAP_W'(1);

   // R2 and R9: reset gives the mode's start value
   a_r2_reset_start: assert property (@(posedge ctl_clk)
      rst |=> tap_cnt == START_V);

   // R3 and R4: step up, modulo the counter width
   a_r3_step_up: assert property (@(posedge ctl_clk) disable iff (rst)
      (STEPS && step_en && step_up && !(LOADS && load))
      |=> tap_cnt == TAP_W'($past(tap_cnt) + ONE_V));

   // R3 and R4: step down, modulo the counter width
   a_r3_step_dn: assert property (@(posedge ctl_clk) disable iff (rst)
      (STEPS && step_en && !step_up && !(LOADS && load))
      |=> tap_cnt == TAP_W'($past(tap_cnt) - ONE_V));

   // R3 and R6: no step and no effective load keeps the count
   a_r3_hold: assert property (@(posedge ctl_clk) disable iff (rst)
      (!step_en && !(LOADS && load)) |=> $stable(tap_cnt));

   // R5 and R7: direct load wins and takes the count input
   a_r5_load: assert property (@(posedge ctl_clk) disable iff (rst)
      (MODE == TAP_LOAD && load) |=> tap_cnt == $past(cnt_in));

   // R8: pipelined load takes the value held before the edge
   a_r8_pipe_xfer: assert property (@(posedge ctl_clk) disable iff (rst)
      (MODE == TAP_LOAD_PIPE && load) |=> tap_cnt == $past(hold_q));

   // R9: reset clears the holding register
   a_r9_hold_clear: assert property (@(posedge ctl_clk)
      (MODE == TAP_LOAD_PIPE && rst) |=> hold_q == '0);

endmodule

bind dly_tap_ctrl dly_tap_ctrl_chk #(
   .TAP_W    (TAP_W),
   .INIT_TAP (INIT_TAP),
   .MODE     (MODE)
) u_chk (
   .ctl_clk (ctl_clk),
   .rst     (rst),
   .step_en (step_en),
   .step_up (step_up),
   .load    (load),
   .cnt_in  (cnt_in),
   .hold_q  (hold_q),
   .tap_cnt (tap_cnt)
);

// File: tb/test_dly_tap_ctrl.sv
`timescale 1ns/1ps
module test_dly_tap_ctrl;
   import dly_tap_pkg::*;

   localparam int W    = 5;
   localparam int INIT = 7;
   localparam int NV   = 17;

   typedef struct packed {
      logic         rst;
      logic         ce;
      logic         up;
      logic         ld;
      logic         stg;
      logic [W-1:0] cin;
      logic [W-1:0] e_fix;
      logic [W-1:0] e_var;
      logic [W-1:0] e_ld;
      logic [W-1:0] e_pipe;
   } vec_t;

   // rst ce up ld stg cin | fixed var load pipe (values after the edge)
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd7, 5'd7,  5'd0,  5'd0 },
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  5'd7, 5'd8,  5'd1,  5'd1 },
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  5'd7, 5'd9,  5'd2,  5'd2 },
      '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  5'd7, 5'd8,  5'd1,  5'd1 },
      '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd7, 5'd8,  5'd1,  5'd1 },
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd20, 5'd7, 5'd8,  5'd20, 5'd0 },
      '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd25, 5'd7, 5'd8,  5'd20, 5'd0 },
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3,  5'd7, 5'd8,  5'd3,  5'd25},
      '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd31, 5'd7, 5'd9,  5'd31, 5'd25},
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  5'd7, 5'd10, 5'd0,  5'd26},
      '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  5'd7, 5'd9,  5'd31, 5'd25},
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd12, 5'd7, 5'd9,  5'd12, 5'd25},
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd7, 5'd9,  5'd0,  5'd12},
      '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  5'd7, 5'd8,  5'd31, 5'd11},
      '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd30, 5'd7, 5'd8,  5'd31, 5'd11},
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd5,  5'd7, 5'd7,  5'd0,  5'd0 },
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd9,  5'd7, 5'd7,  5'd9,  5'd0 }
   };

   localparam string TAGS [NV] = '{
      "R2", "R3", "R3", "R3", "R3", "R5 R6", "R8", "R8", "R7", "R4",
      "R4", "R8", "R8", "R4", "R8", "R9", "R9"
   };

   logic         clk = 1'b0;
   logic         clk_inv = 1'b0;
   logic         rst = 1'b1;
   logic         ce = 1'b0;
   logic         up = 1'b0;
   logic         ld = 1'b0;
   logic         stg = 1'b0;
   logic [W-1:0] cin = '0;
   logic [W-1:0] q_fix, q_var, q_ld, q_pipe;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dly_tap_ctrl #(.TAP_W(W), .INIT_TAP(INIT), .MODE(TAP_FIXED), .CLK_INV_EN(1'b0)) i_dly_tap_ctrl_fix (
      .clk(clk), .clk_inv(clk_inv), .rst(rst), .step_en(ce), .step_up(up),
      .load(ld), .stage(stg), .cnt_in(cin), .tap_cnt(q_fix));

   dly_tap_ctrl #(.TAP_W(W), .INIT_TAP(INIT), .MODE(TAP_VAR), .CLK_INV_EN(1'b1)) i_dly_tap_ctrl_var (
      .clk(clk), .clk_inv(clk_inv), .rst(rst), .step_en(ce), .step_up(up),
      .load(ld), .stage(stg), .cnt_in(cin), .tap_cnt(q_var));

   dly_tap_ctrl #(.TAP_W(W), .INIT_TAP(INIT), .MODE(TAP_LOAD), .CLK_INV_EN(1'b0)) i_dly_tap_ctrl_ld (
      .clk(clk), .clk_inv(clk_inv), .rst(rst), .step_en(ce), .step_up(up),
      .load(ld), .stage(stg), .cnt_in(cin), .tap_cnt(q_ld));

   dly_tap_ctrl #(.TAP_W(W), .INIT_TAP(INIT), .MODE(TAP_LOAD_PIPE), .CLK_INV_EN(1'b0)) i_dly_tap_ctrl (
      .clk(clk), .clk_inv(clk_inv), .rst(rst), .step_en(ce), .step_up(up),
      .load(ld), .stage(stg), .cnt_in(cin), .tap_cnt(q_pipe));

   task automatic check(input string tag, input string what, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic c, input logic u, input logic l,
                        input logic s, input logic [W-1:0] v);
      rst = r; ce = c; up = u; ld = l; stg = s; cin = v;
   endtask

   initial begin : watchdog
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [W-1:0] v0, l0;

      // vector walk: drive after a falling edge, sample at the next falling edge
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].rst, VECS[i].ce, VECS[i].up, VECS[i].ld, VECS[i].stg, VECS[i].cin);
         @(negedge clk);
         check("R1", $sformatf("row %0d fixed", i), q_fix, VECS[i].e_fix);
         check(TAGS[i], $sformatf("row %0d variable", i), q_var, VECS[i].e_var);
         check(TAGS[i], $sformatf("row %0d load", i), q_ld, VECS[i].e_ld);
         check(TAGS[i], $sformatf("row %0d pipe", i), q_pipe, VECS[i].e_pipe);
      end

      // R4: pipelined-mode counter at 0 steps down to 31; variable goes 7 -> 6
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      @(negedge clk);
      check("R4", "pipe wrap down from 0", q_pipe, 5'd31);
      check("R3", "variable step down", q_var, 5'd6);

      // R4: variable 6 -> 31 after 25 steps up, then wraps to 0, then back to 31
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      for (int k = 0; k < 25; k++) @(negedge clk);
      check("R4", "variable reaches 31", q_var, 5'd31);
      @(negedge clk);
      check("R4", "variable wrap up to 0", q_var, 5'd0);
      up = 1'b0;
      @(negedge clk);
      check("R4", "variable wrap down to 31", q_var, 5'd31);
      check("R1", "fixed after stepping", q_fix, 5'd7);
      ce = 1'b0;
      @(negedge clk);
      check("R3", "variable holds with step_en low", q_var, 5'd31);

      // R10: invert the clock while clk is high, step, look between edges
      @(posedge clk);
      #1;
      clk_inv = 1'b1;
      ce = 1'b1;
      up = 1'b1;
      v0 = q_var;
      l0 = q_ld;
      @(negedge clk);
      #1;
      check("R10", "inverted instance stepped on falling edge", q_var, W'(v0 + 1));
      check("R10", "non-inverting instance still waits for rising edge", q_ld, l0);
      clk_inv = 1'b0;
      ce = 1'b0;
      @(posedge clk);
      #1;
      check("R10", "inverted instance after restore", q_var, W'(v0 + 1));
      check("R10", "clk_inv ignored when disabled", q_ld, l0);
      check("R1", "fixed unaffected by clk_inv", q_fix, 5'd7);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule